// File: doc/BRIEF.md
# Accumulator Operate Micro-Op Unit

This block carries out the operate class of instructions for an 18-bit accumulator machine. It owns three 18-bit registers: the accumulator (AC), the memory buffer (MBR) and a live register (LR). An operate word does not carry an encoded opcode. Its low sixteen bits are a set of independent micro-operation controls. These clear either half of AC, OR a light-pen flag or a toggle-switch value into AC, move data between the registers, form a partial (XOR) sum, complement, apply a carry step, and shift or rotate AC. The same word can also request a halt or an IO stop.

A controller presents a word on `instr` and pulses `start`. The block then steps through five fixed phases, one per clock. Each phase reads the register values left by the phase before it. The phases are, in order: load (clears, pen/toggle into AC, and the transfer into MBR), link (MBR into LR), XOR, carry (complement, then the carry add), and shift. One clock after the shift phase, `done` pulses. Splitting addition into an XOR step and a carry step lets a program build a ones'-complement add, or only part of one, from the same micro-op bits.

Bit numbering follows the machine: word bit 0 is the most significant bit and maps to `instr[17]`, and word bit k maps to `instr[17-k]`. In the same way, AC bit 0 (the sign bit) is `ac[17]`. The left half of AC is bits 0–8 (`ac[17:9]`) and the right half is bits 9–17 (`ac[8:0]`).

Top module: `acc_opr_unit`

## Requirements
- R1: While the reset is held, and after it is released, AC, MBR and LR read zero, and `done`, `halt` and `io_stop` are low.
- R2: A `start` pulse sampled while the unit is idle, with word bits 0–1 equal to 11 and no halt latched, is accepted. `done` is then high for exactly one cycle, sampled six clock edges after the accepting edge. The registers already hold their final values in that cycle, and they do not change while the unit is idle.
- R3: A `start` is ignored, producing no `done` and no register change, when word bits 0–1 are not 11 or when the unit is busy with an earlier word.
- R4: In the load phase, word bit 2 (`instr[15]`) clears AC bits 0–8 and word bit 3 (`instr[14]`) clears AC bits 9–17.
- R5: In the load phase, after the clears: if word bit 11 (`instr[6]`) is set and bit 15 (`instr[2]`) is clear, `pen_hit` is ORed into AC bits 0 and 1. If bit 11 is clear and bit 15 is set, `toggle_sw` is ORed into AC.
- R6: In the load phase, word bits 16–17 (`instr[1:0]`) select the MBR update. 01 copies AC as it stood at the start of the word, 10 copies LR, 11 ORs `toggle_sw` into MBR, and 00 leaves MBR unchanged.
- R7: In the link phase, if word bits 9–10 (`instr[8:7]`) are 01, LR takes the MBR value left by the load phase. Whenever LR changes, its new value is the MBR value of the cycle before.
- R8: In the XOR phase, word bit 13 (`instr[4]`) replaces AC with AC XOR MBR.
- R9: In the carry phase, word bit 12 (`instr[5]`) first complements AC. Word bit 14 (`instr[3]`) then adds, end-around, the carry word (AC AND MBR as they stood at the XOR phase) rotated one place toward bit 0. With bits 13 and 14 both set, AC ends as the ones'-complement sum of AC and MBR.
- R10: In the shift phase, word bits 9–10 equal to 10 shift AC right one place and keep the sign bit. Equal to 11, they rotate AC right, with bit 17 moving to bit 0.
- R11: If word bits 4–5 (`instr[13:12]`) are 10, `io_stop` is high during the `done` cycle and `io_code` shows word bits 6–8 (`instr[11:9]`). At all other times `io_stop` is low.
- R12: If word bits 4–5 are 11, `halt` rises with the `done` of that word and stays high until reset. While halted, every `start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request to execute `instr` |
| instr | input | 18 | Instruction word; word bit k is `instr[17-k]` |
| toggle_sw | input | 18 | Toggle-switch value, read in the load phase |
| pen_hit | input | 1 | Light-pen flag, read in the load phase |
| done | output | 1 | One-cycle pulse after the last phase of an accepted word |
| halt | output | 1 | Latched halt request |
| io_stop | output | 1 | IO stop request, valid with `done` |
| io_code | output | 3 | IO operation code, valid while `io_stop` is high |
| ac | output | 18 | Accumulator |
| mbr | output | 18 | Memory buffer register |
| lr | output | 18 | Live register |

## Verification
The bench sets each micro-op bit on its own to isolate it. It then runs add pairs that cover a plain positive sum, a negative plus a positive that needs the end-around carry, an overflow into the sign bit, and minus zero plus minus zero. These pairs separate a correct carry word and rotation from a two's-complement adder. Words that combine a clear, a toggle load, an MBR transfer, XOR and complement show whether the phases run in their fixed order and whether the MBR copy takes the start-of-word AC. Further cases cover a shift and a rotate of values whose sign and low bits differ, words with a non-operate opcode, a second `start` while busy, and a `start` after halt. Together these show which requests must be dropped.

// File: rtl/acc_opr_pkg.sv
package acc_opr_pkg;

  localparam int WORD_W = 18;

  // execution phases, in their fixed order
  localparam int PH_LOAD  = 0;
  localparam int PH_LINK  = 1;
  localparam int PH_XOR   = 2;
  localparam int PH_CARRY = 3;
  localparam int PH_SHIFT = 4;
  localparam int NUM_PH   = 5;

  // MBR source field (word bits 16-17)
  typedef enum logic [1:0] {
    MSRC_KEEP = 2'b00,
    MSRC_AC   = 2'b01,
    MSRC_LR   = 2'b10,
    MSRC_TOG  = 2'b11
  } msrc_e;

  // link / shift field (word bits 9-10)
  typedef enum logic [1:0] {
    XF_NONE = 2'b00,
    XF_LINK = 2'b01,
    XF_SHR  = 2'b10,
    XF_ROR  = 2'b11
  } xfer_e;

  typedef struct packed {
    logic  clr_left;
    logic  clr_right;
    logic  pen_or;
    logic  tog_or;
    msrc_e msrc;
    xfer_e xfer;
    logic  cmpl;
    logic  xor_add;
    logic  carry;
  } uop_t;

endpackage

// File: rtl/acc_opr_decode.sv
module acc_opr_decode
  import acc_opr_pkg::*;
(
  input  logic [15:0] word_lo,   // word bits 2..17, word bit k at index 17-k
  output uop_t        uop,
  output logic        io_req,
  output logic        halt_req,
  output logic [2:0]  io_op
);

  always_comb begin
    uop.clr_left  = word_lo[15];            // bit 2
    uop.clr_right = word_lo[14];            // bit 3
    uop.pen_or    = word_lo[6] & ~word_lo[2];  // bit 11 set, bit 15 clear
    uop.tog_or    = ~word_lo[6] & word_lo[2];  // bit 11 clear, bit 15 set
    uop.msrc      = msrc_e'(word_lo[1:0]);  // bits 16-17
    uop.xfer      = xfer_e'(word_lo[8:7]);  // bits 9-10
    uop.cmpl      = word_lo[5];             // bit 12
    uop.xor_add   = word_lo[4];             // bit 13
    uop.carry     = word_lo[3];             // bit 14
    io_req        = (word_lo[13:12] == 2'b10);  // bits 4-5
    halt_req      = (word_lo[13:12] == 2'b11);
    io_op         = word_lo[11:9];          // bits 6-8
  end

endmodule

// File: rtl/acc_opr_seq.sv
module acc_opr_seq #(
  parameter int N_PH = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  output logic            busy,
  output logic            done,
  output logic [N_PH-1:0] ph
);

  localparam int CW = (N_PH > 1) ? $clog2(N_PH) : 1;
  localparam logic [CW-1:0] LAST = CW'(N_PH - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_e;

  st_e           st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      S_IDLE: if (go) begin
        st_d  = S_RUN;
        cnt_d = '0;
      end
      S_RUN: begin
        if (cnt_q == LAST) st_d = S_FIN;
        else               cnt_d = cnt_q + CW'(1);
      end
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < N_PH; i++) begin : g_ph
    assign ph[i] = (st_q == S_RUN) && (cnt_q == CW'(i));
  end

  assign busy = (st_q != S_IDLE);
  assign done = (st_q == S_FIN);

endmodule

// File: rtl/acc_opr_ocadd.sv
module acc_opr_ocadd #(
  parameter int W = 18
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s
);

  logic [W:0] raw;

  always_comb begin
    raw = {1'b0, a} + {1'b0, b};
    // the carry out of the top wraps into the bottom; cannot overflow again
    s   = raw[W-1:0] + W'(raw[W]);
  end

endmodule

// File: rtl/acc_opr_datapath.sv
module acc_opr_datapath
  import acc_opr_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NUM_PH-1:0] ph,
  input  uop_t          uop,
  input  logic [W-1:0]  tog,
  input  logic          pen,
  output logic [W-1:0]  ac_q,
  output logic [W-1:0]  mbr_q,
  output logic [W-1:0]  lr_q
);

  localparam int HALF = W / 2;
  localparam logic [W-1:0] LEFT_MASK  = {{HALF{1'b1}}, {(W-HALF){1'b0}}};
  localparam logic [W-1:0] RIGHT_MASK = ~LEFT_MASK;

  logic [W-1:0] ac_d, mbr_d, lr_d, cy_q, cy_d;
  logic [W-1:0] add_a, add_b, add_s;
  logic         ld_en;

  // carry path: complemented (or not) AC plus carry word rotated toward bit 0
  assign add_a = uop.cmpl ? ~ac_q : ac_q;
  assign add_b = {cy_q[W-2:0], cy_q[W-1]};

  acc_opr_ocadd #(.W(W)) u_add (
    .a (add_a),
    .b (add_b),
    .s (add_s)
  );

  always_comb begin
    ac_d  = ac_q;
    mbr_d = mbr_q;
    lr_d  = lr_q;
    cy_d  = cy_q;

    if (ph[PH_LOAD]) begin
      ac_d = ac_q;
      if (uop.clr_left)  ac_d = ac_d & ~LEFT_MASK;
      if (uop.clr_right) ac_d = ac_d & ~RIGHT_MASK;
      if (uop.pen_or)    ac_d[W-1:W-2] = ac_d[W-1:W-2] | {2{pen}};
      if (uop.tog_or)    ac_d = ac_d | tog;
      case (uop.msrc)
        MSRC_AC:  mbr_d = ac_q;
        MSRC_LR:  mbr_d = lr_q;
        MSRC_TOG: mbr_d = mbr_q | tog;
        default:  mbr_d = mbr_q;
      endcase
    end

    if (ph[PH_LINK] && (uop.xfer == XF_LINK)) lr_d = mbr_q;

    if (ph[PH_XOR]) begin
      cy_d = ac_q & mbr_q;
      if (uop.xor_add) ac_d = ac_q ^ mbr_q;
    end

    if (ph[PH_CARRY]) begin
      if (uop.carry)     ac_d = add_s;
      else if (uop.cmpl) ac_d = ~ac_q;
    end

    if (ph[PH_SHIFT]) begin
      case (uop.xfer)
        XF_SHR:  ac_d = {ac_q[W-1], ac_q[W-1:1]};
        XF_ROR:  ac_d = {ac_q[0], ac_q[W-1:1]};
        default: ac_d = ac_q;
      endcase
    end
  end

  assign ld_en = |ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q  <= '0;
      mbr_q <= '0;
      lr_q  <= '0;
      cy_q  <= '0;
    end else if (ld_en) begin
      ac_q  <= ac_d;
      mbr_q <= mbr_d;
      lr_q  <= lr_d;
      cy_q  <= cy_d;
    end
  end

endmodule

// File: rtl/acc_opr_unit.sv
module acc_opr_unit
  import acc_opr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [17:0] instr,
  input  logic [17:0] toggle_sw,
  input  logic        pen_hit,
  output logic        done,
  output logic        halt,
  output logic        io_stop,
  output logic [2:0]  io_code,
  output logic [17:0] ac,
  output logic [17:0] mbr,
  output logic [17:0] lr
);

  logic              rst_meta, rst_i;
  logic              busy, go, halt_q, halt_d, ir_en;
  logic [15:0]       ir_q, ir_d;
  logic [NUM_PH-1:0] ph;
  uop_t              uop;
  logic              io_req, halt_req;
  logic [2:0]        io_op;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  assign go    = start && !busy && !halt_q && (instr[17:16] == 2'b11);
  assign ir_en = go;
  assign ir_d  = instr[15:0];

  always_comb begin
    halt_d = halt_q;
    if (ph[PH_SHIFT] && halt_req) halt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ir_q   <= '0;
      halt_q <= 1'b0;
    end else begin
      if (ir_en) ir_q <= ir_d;
      halt_q <= halt_d;
    end
  end

  acc_opr_decode u_dec (
    .word_lo  (ir_q),
    .uop      (uop),
    .io_req   (io_req),
    .halt_req (halt_req),
    .io_op    (io_op)
  );

  acc_opr_seq #(.N_PH(NUM_PH)) u_seq (
    .clk   (clk),
    .rst_n (rst_i),
    .go    (go),
    .busy  (busy),
    .done  (done),
    .ph    (ph)
  );

  acc_opr_datapath #(.W(WORD_W)) u_dp (
    .clk   (clk),
    .rst_n (rst_i),
    .ph    (ph),
    .uop   (uop),
    .tog   (toggle_sw),
    .pen   (pen_hit),
    .ac_q  (ac),
    .mbr_q (mbr),
    .lr_q  (lr)
  );

  assign halt    = halt_q;
  assign io_stop = done && io_req;
  assign io_code = io_stop ? io_op : 3'b000;

endmodule

// File: rtl/acc_opr_checker.sv
module acc_opr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        halt,
  input logic        io_stop,
  input logic [17:0] ac,
  input logic [17:0] mbr,
  input logic [17:0] lr
);

  // R2: done lasts a single cycle
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2, R3: registers hold while idle
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(ac) && $stable(mbr) && $stable(lr)));

  // R7: LR only ever takes the MBR value of the previous cycle
  p_lr_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lr) |-> (lr == $past(mbr)));

  // R11: IO stop appears only with done
  p_io_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    io_stop |-> done);

  // R12: halt is sticky
  p_halt_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);

  // R12: nothing completes once halted
  p_halt_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !done) |=> !done);

endmodule

bind acc_opr_unit acc_opr_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_i),
  .busy    (busy),
  .done    (done),
  .halt    (halt),
  .io_stop (io_stop),
  .ac      (ac),
  .mbr     (mbr),
  .lr      (lr)
);

// File: tb/tb_acc_opr_unit.sv
module tb_acc_opr_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [17:0] instr = '0;
  logic [17:0] toggle_sw = '0;
  logic        pen_hit = 1'b0;
  logic        done, halt, io_stop;
  logic [2:0]  io_code;
  logic [17:0] ac, mbr, lr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  acc_opr_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .toggle_sw(toggle_sw), .pen_hit(pen_hit), .done(done), .halt(halt),
    .io_stop(io_stop), .io_code(io_code), .ac(ac), .mbr(mbr), .lr(lr)
  );

  typedef struct {
    logic [17:0] ac, mbr, lr;
    logic        halt, io;
    logic [2:0]  code;
    string       req;
  } exp_t;

  exp_t sb_q[$];

  // model of the architectural state
  logic [17:0] m_ac = '0, m_mbr = '0, m_lr = '0;
  logic        m_halt = 1'b0;

  // word bit k (bit 0 is the MSB)
  function automatic logic [17:0] fb(input int k);
    return 18'(1) << (17 - k);
  endfunction

  localparam logic [17:0] OPR = 18'h30000;

  function automatic logic [17:0] oc_add(input logic [17:0] a, input logic [17:0] b);
    logic [18:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[18] ? t[17:0] + 18'd1 : t[17:0];
  endfunction

  task automatic predict(input logic [17:0] w, input string req);
    logic [17:0] a, m, l, c;
    exp_t e;
    a = m_ac; m = m_mbr; l = m_lr;
    if (w[15]) a = a & 18'h001FF;             // bit 2
    if (w[14]) a = a & 18'h3FE00;             // bit 3
    if (w[6] && !w[2]) a[17:16] = a[17:16] | {pen_hit, pen_hit};
    if (!w[6] && w[2]) a = a | toggle_sw;
    case (w[1:0])
      2'b01: m = m_ac;
      2'b10: m = m_lr;
      2'b11: m = m_mbr | toggle_sw;
      default: ;
    endcase
    if (w[8:7] == 2'b01) l = m;
    c = a & m;
    if (w[4]) a = a ^ m;
    if (w[5]) a = ~a;
    if (w[3]) a = oc_add(a, {c[16:0], c[17]});
    if (w[8:7] == 2'b10) a = {a[17], a[17:1]};
    else if (w[8:7] == 2'b11) a = {a[0], a[17:1]};
    if (w[13:12] == 2'b11) m_halt = 1'b1;
    m_ac = a; m_mbr = m; m_lr = l;
    e.ac = a; e.mbr = m; e.lr = l; e.halt = m_halt;
    e.io = (w[13:12] == 2'b10);
    e.code = e.io ? w[11:9] : 3'b000;
    e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic check(input bit ok, input string req, input logic [17:0] act,
                       input logic [17:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // monitor: pops the scoreboard on every done
  always @(negedge clk) begin
    if (rst_n && done && !finished) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R3 unexpected done", 18'd1, 18'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(ac == e.ac, {e.req, " ac"}, ac, e.ac);
        check(mbr == e.mbr, {e.req, " mbr"}, mbr, e.mbr);
        check(lr == e.lr, {e.req, " lr"}, lr, e.lr);
        check(halt == e.halt, {e.req, " halt (R12)"}, 18'(halt), 18'(e.halt));
        check(io_stop == e.io && io_code == e.code, {e.req, " io (R11)"},
              {14'd0, io_stop, io_code}, {14'd0, e.io, e.code});
      end
    end
  end

  task automatic run_op(input logic [17:0] w, input logic [17:0] tog,
                        input logic pen, input string req);
    int lat;
    @(negedge clk);
    toggle_sw = tog; pen_hit = pen;
    predict(w, req);
    instr = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 6, {req, " latency R2"}, 18'(lat), 18'd6);
  endtask

  task automatic set_ac(input logic [17:0] v);
    run_op(OPR | fb(2) | fb(3) | fb(15), v, 1'b0, "R5 toggle load");
  endtask

  task automatic set_mbr(input logic [17:0] v);
    set_ac(v);
    run_op(OPR | fb(17), '0, 1'b0, "R6 ac to mbr");
  endtask

  task automatic add_pair(input logic [17:0] a, input logic [17:0] b);
    logic [17:0] expv;
    set_mbr(b);
    set_ac(a);
    run_op(OPR | fb(13) | fb(14), '0, 1'b0, "R9 ones add");
    expv = oc_add(a, b);
    @(negedge clk);
    check(ac == expv, "R9 sum", ac, expv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ac == 0 && mbr == 0 && lr == 0, "R1 regs in reset", ac | mbr | lr, 18'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!done && !halt && !io_stop && ac == 0, "R1 after reset",
          {15'd0, done, halt, io_stop}, 18'd0);

    set_ac(18'h2A5A5);
    set_mbr(18'h2A5A5);
    run_op(OPR | fb(2), '0, 1'b0, "R4 clear left");
    set_ac(18'h3FFFF);
    run_op(OPR | fb(3), '0, 1'b0, "R4 clear right");
    set_mbr(18'h1234F);
    run_op(OPR | fb(10), '0, 1'b0, "R7 mbr to lr");
    set_mbr(18'h00777);
    run_op(OPR | fb(16), '0, 1'b0, "R6 lr to mbr");
    run_op(OPR | fb(16) | fb(17), 18'h30001, 1'b0, "R6 toggle or mbr");
    set_ac(18'h0F0F0);
    run_op(OPR | fb(13), '0, 1'b0, "R8 xor");
    run_op(OPR | fb(12), '0, 1'b0, "R9 complement");

    add_pair(18'd5, 18'd3);
    add_pair(18'h3FFFE, 18'd5);
    add_pair(18'h1FFFF, 18'd1);
    add_pair(18'h3FFFF, 18'h3FFFF);

    set_ac(18'h20004);
    run_op(OPR | fb(9), '0, 1'b0, "R10 shift right");
    @(negedge clk);
    check(ac == 18'h30002, "R10 sign kept", ac, 18'h30002);
    set_ac(18'h00001);
    run_op(OPR | fb(9) | fb(10), '0, 1'b0, "R10 rotate right");
    @(negedge clk);
    check(ac == 18'h20000, "R10 bit 17 to bit 0", ac, 18'h20000);

    set_ac(18'h00000);
    run_op(OPR | fb(11), '0, 1'b1, "R5 pen set");
    run_op(OPR | fb(2) | fb(11), '0, 1'b0, "R5 pen clear");
    run_op(OPR | fb(11) | fb(15), 18'h3FFFF, 1'b1, "R5 both bits no or");

    set_ac(18'h0000F);
    run_op(OPR | fb(2) | fb(3) | fb(15) | fb(17) | fb(13) | fb(12), 18'h00FF0,
           1'b0, "R6 phase order");

    run_op(OPR | fb(4) | fb(7) | fb(8), '0, 1'b0, "R11 io stop");

    // R3: non-operate opcode is ignored, then a no-op confirms state
    @(negedge clk);
    instr = fb(1) | fb(2) | fb(3); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    run_op(OPR, '0, 1'b0, "R3 ignored non-operate");

    // R3: start while busy is ignored
    @(negedge clk);
    predict(OPR | fb(12), "R3 busy start");
    instr = OPR | fb(12); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    instr = OPR | fb(2) | fb(3); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);

    // R12: halt latches, later starts ignored
    run_op(OPR | fb(4) | fb(5), '0, 1'b0, "R12 halt");
    @(negedge clk);
    instr = OPR | fb(2) | fb(3); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    check(ac == m_ac, "R12 start ignored when halted", ac, m_ac);
    check(halt == 1'b1, "R12 halt held", 18'(halt), 18'd1);
    check(sb_q.size() == 0, "R2 all results seen", 18'(sb_q.size()), 18'd0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule